// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Packet Fabric

The fabric connects N endpoints (N a power of two) through K = log2(N) ranks of two-by-two steering elements. Before every rank the lanes are re-wired by a perfect shuffle. Each element forwards a packet to its upper or lower output according to one bit of the packet's destination index. No table and no central scheduler is involved: the destination bits alone pick the path.

Every input lane offers a valid flag, a destination index and a payload word each cycle. All packets presented in the same cycle form a wave. Each rank ends in a register, so a wave leaves the fabric exactly K cycles after it enters. A new wave can enter every cycle.

When two packets in one element ask for the same output, one is kept and the other is discarded. The discarded packet is reported on a per-source blocked vector, aligned with the cycle in which its wave is delivered. Every valid input therefore ends in exactly one of two ways: it is delivered, or it is flagged as blocked.

Top module: `omega_fabric`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low, every bit of `out_valid` and `blocked` is 0.
- R2: A packet presented in cycle c appears at the outputs in cycle c+K, where K = log2(N). An idle cycle produces no output K cycles later.
- R3: A delivered packet leaves on the output lane whose index equals its destination. `out_src` on that lane holds the index of the input that sent it, and `out_data` holds the payload unchanged.
- R4: Before each rank, lane p moves to the lane whose index is p rotated left by one bit. Rank s (counted from 0) steers on destination bit K-1-s. A 0 selects the even (upper) output 2e of element e, and a 1 selects the odd (lower) output 2e+1. Packets whose paths share no element output all arrive.
- R5: When both inputs of an element request the same output, the packet on the even (upper) input lane is kept and the packet on the odd (lower) input lane is discarded.
- R6: `blocked[i]` (bit index = input index) is 1 in the cycle in which input i's wave is delivered, exactly when input i's packet was discarded. No valid input is both delivered and blocked.
- R7: When every input sends to its own index, all N packets are delivered in the same wave.
- R8: When all N inputs send to one destination, exactly one packet is delivered and the other N-1 are flagged blocked.
- R9: An input lane with `in_valid` low has no effect. Its destination and payload produce no output, no blocked flag and no change to other packets.
- R10: Waves presented in consecutive cycles are routed independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N | Per-lane packet present |
| in_dest | input | N x log2(N) | Per-lane destination index |
| in_data | input | N x W | Per-lane payload |
| out_valid | output | N | Output lane carries a delivered packet |
| out_src | output | N x log2(N) | Input index of the delivered packet |
| out_data | output | N x W | Payload of the delivered packet |
| blocked | output | N | Per-source flag: the packet from this input was discarded |

## Verification
The following properties are checked on every cycle:
- Each rank conserves packets: those entering equal those leaving plus those newly discarded.
- No source is discarded twice within a wave.
- A registered rank holds data only if its inputs were busy one cycle earlier.
- A valid output always sits on the lane its destination names.
- An idle input cycle leaves rank 0 empty.
- The outputs are quiet during reset.

Other behaviour can only be shown by the bench's scenarios, which compare against an independent path model. This covers which packet wins a conflict, the exact K-cycle alignment of deliveries and blocked flags, the identity and all-to-one extremes, and the fact that garbage on invalid lanes changes nothing.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Lane index reached by lane idx through a perfect shuffle on 'bits' bits
  function automatic int shuffle_dst(input int idx, input int bits);
    int mask;
    mask = (1 << bits) - 1;
    return ((idx << 1) | (idx >> (bits - 1))) & mask;
  endfunction

  // Destination bit position examined by a given rank (MSB first)
  function automatic int steer_pos(input int rank, input int bits);
    return bits - 1 - rank;
  endfunction

endpackage

// File: rtl/omega_shuffle.sv
module omega_shuffle #(
  parameter int N  = 8,
  parameter int LW = 8,
  localparam int K = $clog2(N)
) (
  input  logic [N-1:0][LW-1:0] lane_i,
  output logic [N-1:0][LW-1:0] lane_o
);

  for (genvar p = 0; p < N; p++) begin : g_wire
    localparam int DST = omega_pkg::shuffle_dst(p, K);
    assign lane_o[DST] = lane_i[p];
  end

endmodule

// File: rtl/omega_switch2x2.sv
module omega_switch2x2 #(
  parameter int LW     = 8,
  parameter int A      = 3,
  parameter int BITPOS = 0
) (
  input  logic [LW-1:0] up_i,
  input  logic [LW-1:0] lo_i,
  output logic [LW-1:0] even_o,
  output logic [LW-1:0] odd_o,
  output logic          lo_lost_o
);

  // Lane layout: {valid, dest[A], src[A], data}; dest LSB sits at LW-1-A
  localparam int DB = LW - 1 - A + BITPOS;

  logic up_v, lo_v, up_b, lo_b;

  assign up_v = up_i[LW-1];
  assign lo_v = lo_i[LW-1];
  assign up_b = up_i[DB];
  assign lo_b = lo_i[DB];

  always_comb begin
    even_o = '0;
    odd_o  = '0;
    if (lo_v && !lo_b) even_o = lo_i;
    if (lo_v &&  lo_b) odd_o  = lo_i;
    // the upper input overrides on a shared request
    if (up_v && !up_b) even_o = up_i;
    if (up_v &&  up_b) odd_o  = up_i;
  end

  assign lo_lost_o = up_v && lo_v && (up_b == lo_b);

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int N = 8,
  parameter int W = 16,
  parameter int S = 0,
  localparam int A  = $clog2(N),
  localparam int LW = 1 + 2 * A + W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0][LW-1:0] lane_i,
  input  logic [N-1:0]         drop_i,
  output logic [N-1:0][LW-1:0] lane_q,
  output logic [N-1:0]         drop_q,
  output logic [N-1:0]         pre_valid_o,
  output logic [N-1:0]         sw_valid_o,
  output logic [N-1:0]         q_valid_o,
  output logic [N-1:0]         new_drop_o
);

  localparam int HALF   = N / 2;
  localparam int BITPOS = omega_pkg::steer_pos(S, A);

  logic [N-1:0][LW-1:0] shuffled;
  logic [N-1:0][LW-1:0] switched;
  logic [HALF-1:0]      lo_lost;
  logic [HALF-1:0][A-1:0] lo_src;

  omega_shuffle #(.N(N), .LW(LW)) u_shuffle (
    .lane_i(lane_i),
    .lane_o(shuffled)
  );

  for (genvar e = 0; e < HALF; e++) begin : g_elem
    omega_switch2x2 #(.LW(LW), .A(A), .BITPOS(BITPOS)) u_sw (
      .up_i     (shuffled[2*e]),
      .lo_i     (shuffled[2*e+1]),
      .even_o   (switched[2*e]),
      .odd_o    (switched[2*e+1]),
      .lo_lost_o(lo_lost[e])
    );
    assign lo_src[e] = shuffled[2*e+1][A+W-1 -: A];
  end

  always_comb begin
    new_drop_o = '0;
    for (int e = 0; e < HALF; e++) begin
      if (lo_lost[e]) new_drop_o[lo_src[e]] = 1'b1;
    end
  end

  for (genvar p = 0; p < N; p++) begin : g_obs
    assign pre_valid_o[p] = shuffled[p][LW-1];
    assign sw_valid_o[p]  = switched[p][LW-1];
    assign q_valid_o[p]   = lane_q[p][LW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      drop_q <= '0;
    end else begin
      lane_q <= switched;
      drop_q <= drop_i | new_drop_o;
    end
  end

endmodule

// File: rtl/omega_fabric.sv
module omega_fabric #(
  parameter int N = 8,
  parameter int W = 16,
  localparam int A = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        in_valid,
  input  logic [N-1:0][A-1:0] in_dest,
  input  logic [N-1:0][W-1:0] in_data,
  output logic [N-1:0]        out_valid,
  output logic [N-1:0][A-1:0] out_src,
  output logic [N-1:0][W-1:0] out_data,
  output logic [N-1:0]        blocked
);

  localparam int K  = A;
  localparam int LW = 1 + 2 * A + W;

  logic [N-1:0][LW-1:0] lanes [K+1];
  logic [N-1:0]         drops [K+1];

  // observation wires for the bound checker
  logic [N-1:0]         st_pre_valid [K];
  logic [N-1:0]         st_sw_valid  [K];
  logic [N-1:0]         st_q_valid   [K];
  logic [N-1:0]         st_new_drop  [K];
  logic [N-1:0]         st_drop_in   [K];
  logic [N-1:0][A-1:0]  fin_dest;

  for (genvar p = 0; p < N; p++) begin : g_entry
    assign lanes[0][p] = in_valid[p] ? {1'b1, in_dest[p], A'(p), in_data[p]}
                                     : '0;
  end
  assign drops[0] = '0;

  for (genvar s = 0; s < K; s++) begin : g_rank
    omega_stage #(.N(N), .W(W), .S(s)) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .lane_i     (lanes[s]),
      .drop_i     (drops[s]),
      .lane_q     (lanes[s+1]),
      .drop_q     (drops[s+1]),
      .pre_valid_o(st_pre_valid[s]),
      .sw_valid_o (st_sw_valid[s]),
      .q_valid_o  (st_q_valid[s]),
      .new_drop_o (st_new_drop[s])
    );
    assign st_drop_in[s] = drops[s];
  end

  for (genvar p = 0; p < N; p++) begin : g_exit
    assign out_valid[p] = lanes[K][p][LW-1];
    assign fin_dest[p]  = lanes[K][p][LW-2 -: A];
    assign out_src[p]   = lanes[K][p][A+W-1 -: A];
    assign out_data[p]  = lanes[K][p][W-1:0];
  end

  assign blocked = drops[K];

endmodule

// File: rtl/omega_fabric_chk.sv
module omega_fabric_chk #(
  parameter int N = 8,
  parameter int K = 3,
  parameter int A = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N-1:0]        in_valid,
  input logic [N-1:0]        out_valid,
  input logic [N-1:0]        blocked,
  input logic [N-1:0][A-1:0] fin_dest,
  input logic [N-1:0]        st_pre_valid [K],
  input logic [N-1:0]        st_sw_valid  [K],
  input logic [N-1:0]        st_q_valid   [K],
  input logic [N-1:0]        st_new_drop  [K],
  input logic [N-1:0]        st_drop_in   [K]
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (out_valid == '0 && blocked == '0));

  // R9
  idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid == '0) |=> (st_q_valid[0] == '0));

  for (genvar s = 0; s < K; s++) begin : g_rank_chk
    // R6
    conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(st_pre_valid[s]) ==
      $countones(st_sw_valid[s]) + $countones(st_new_drop[s]));

    // R6
    drop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_new_drop[s] & st_drop_in[s]) == '0);

    // R2
    rank_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q_valid[s] != '0) |-> $past(st_pre_valid[s] != '0));
  end

  for (genvar j = 0; j < N; j++) begin : g_lane_chk
    // R3
    dest_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[j] |-> (fin_dest[j] == A'(j)));
  end

endmodule

bind omega_fabric omega_fabric_chk #(.N(N), .K(K), .A(A)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .blocked     (blocked),
  .fin_dest    (fin_dest),
  .st_pre_valid(st_pre_valid),
  .st_sw_valid (st_sw_valid),
  .st_q_valid  (st_q_valid),
  .st_new_drop (st_new_drop),
  .st_drop_in  (st_drop_in)
);

// File: tb/tb_omega_fabric.sv
module tb_omega_fabric;

  localparam int N = 8;
  localparam int W = 16;
  localparam int A = 3;
  localparam int K = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                rst_n = 1'b1;
  logic [N-1:0]        in_valid = '0;
  logic [N-1:0][A-1:0] in_dest  = '0;
  logic [N-1:0][W-1:0] in_data  = '0;
  logic [N-1:0]        out_valid;
  logic [N-1:0][A-1:0] out_src;
  logic [N-1:0][W-1:0] out_data;
  logic [N-1:0]        blocked;

  omega_fabric #(.N(N), .W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
    .out_valid(out_valid), .out_src(out_src), .out_data(out_data),
    .blocked(blocked)
  );

  typedef struct packed {
    logic [N-1:0]        v;
    logic [N-1:0]        blk;
    logic [N-1:0][A-1:0] src;
    logic [N-1:0][W-1:0] data;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int compared   = 0;
  int mismatched = 0;
  int wave_no    = 0;

  // window position of a packet (source p, dest d) after rank s
  function automatic int pos_after(input int p, input int d, input int s);
    return ((p << (s + 1)) | (d >> (K - 1 - s))) & (N - 1);
  endfunction

  task automatic send(input logic [N-1:0] v, input logic [N-1:0][A-1:0] d,
                      input string tag);
    exp_t e;
    logic [N-1:0] alive;
    logic [N-1:0][W-1:0] pl;
    e = '0;
    alive = v;
    for (int i = 0; i < N; i++) pl[i] = W'(wave_no * 37 + i * 4099 + 5);
    for (int s = 0; s < K; s++) begin
      for (int p = 0; p < N; p++) begin
        for (int q = p + 1; q < N; q++) begin
          if (alive[p] && alive[q] &&
              pos_after(p, int'(d[p]), s) == pos_after(q, int'(d[q]), s)) begin
            // the source whose entry slot is odd loses
            if (((p >> (K - 1 - s)) & 1) == 1) begin
              alive[p] = 1'b0; e.blk[p] = 1'b1;
            end else begin
              alive[q] = 1'b0; e.blk[q] = 1'b1;
            end
          end
        end
      end
    end
    for (int p = 0; p < N; p++) begin
      if (alive[p]) begin
        e.v[d[p]]    = 1'b1;
        e.src[d[p]]  = A'(p);
        e.data[d[p]] = pl[p];
      end
    end
    @(negedge clk);
    in_valid = v;
    in_dest  = d;
    in_data  = pl;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    wave_no++;
  endtask

  // monitor
  initial begin
    exp_t  e;
    string t;
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() >= K) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compared++;
        if (out_valid !== e.v || blocked !== e.blk) begin
          mismatched++;
          $display("FAIL %s: out_valid=%b blocked=%b expected out_valid=%b blocked=%b",
                   t, out_valid, blocked, e.v, e.blk);
        end
        for (int j = 0; j < N; j++) begin
          if (e.v[j]) begin
            compared++;
            if (out_src[j] !== e.src[j] || out_data[j] !== e.data[j]) begin
              mismatched++;
              $display("FAIL %s R3 lane %0d: src=%0d data=%h expected src=%0d data=%h",
                       t, j, out_src[j], out_data[j], e.src[j], e.data[j]);
            end
          end
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    mismatched++;
    $display("FAIL R10 watchdog: run did not finish, actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  function automatic logic [A-1:0] bitrev(input int x);
    logic [A-1:0] r;
    for (int b = 0; b < A; b++) r[b] = 1'(x >> (A - 1 - b));
    return r;
  endfunction

  initial begin
    logic [N-1:0][A-1:0] d;
    #1 rst_n = 1'b0;
    repeat (3) begin
      @(posedge clk);
      #5;
      compared++;
      if (out_valid !== '0 || blocked !== '0) begin
        mismatched++;
        $display("FAIL R1: out_valid=%b blocked=%b expected 0/0", out_valid, blocked);
      end
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2: lone packet, then idle waves
    d = '0; d[3] = 3'd6;
    send(8'b0000_1000, d, "R2");
    for (int i = 0; i < K + 1; i++) send('0, d, "R2");

    // R7: identity
    for (int i = 0; i < N; i++) d[i] = A'(i);
    send('1, d, "R7");

    // R3: reversal, rotation, bit reversal permutations
    for (int i = 0; i < N; i++) d[i] = A'(N - 1 - i);
    send('1, d, "R3");
    for (int i = 0; i < N; i++) d[i] = A'((i + 1) % N);
    send('1, d, "R3");
    for (int i = 0; i < N; i++) d[i] = bitrev(i);
    send('1, d, "R3");

    // R8: all to one destination
    for (int i = 0; i < N; i++) d[i] = 3'd0;
    send('1, d, "R8");
    for (int i = 0; i < N; i++) d[i] = 3'd5;
    send('1, d, "R8");

    // R5: inputs 0 and 4 meet in element 0 of rank 0, both want dest 2
    d = '0; d[0] = 3'd2; d[4] = 3'd2;
    send(8'b0001_0001, d, "R5");
    d = '0; d[2] = 3'd7; d[6] = 3'd7;
    send(8'b0100_0100, d, "R5");

    // R4: same element, differing MSB, no conflict
    d = '0; d[0] = 3'd1; d[4] = 3'd5;
    send(8'b0001_0001, d, "R4");
    d = '0; d[1] = 3'd6; d[5] = 3'd2;
    send(8'b0010_0010, d, "R4");

    // R9: invalid lanes carry colliding garbage
    for (int i = 0; i < N; i++) d[i] = A'(i);
    d[1] = 3'd0; d[3] = 3'd2; d[4] = 3'd0; d[6] = 3'd5;
    send(8'b1010_0101, d, "R9");

    // R6: dense contention
    for (int i = 0; i < N; i++) d[i] = A'(i % 2);
    send('1, d, "R6");

    // R10: back-to-back random waves
    for (int w = 0; w < 200; w++) begin
      for (int i = 0; i < N; i++) d[i] = A'($urandom);
      send(N'($urandom), d, "R10");
    end

    for (int i = 0; i < K; i++) send('0, d, "R2");
    repeat (2) @(posedge clk);
    #6;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule